// File: doc/BRIEF.md
# Bus Release Arbiter for an External Memory Master

This block sits inside a bus master that normally owns an external memory bus. It hands that bus to an outside requester through an active-low request/acknowledge handshake, and later takes it back. Before it lets go, it waits for the bus cycle in progress to finish. If a DRAM or SDRAM bank is still open, it also has the memory controller precharge that bank. It then drives the tri-state enables of the control group and of the address/data groups in a fixed order, both on the way out and on the way back.

The release path has three steps. First the acknowledge goes low for one cycle while every group is still driven, with the control strobes parked at their idle level. All groups float on the next edge. The return path has two steps. On the first edge the control group is driven and the acknowledge goes high. On the second edge the address and data groups are driven. At that second edge the internal access logic sees `bus_owned_o` rise and may start a cycle.

While the bus is released, an internal refresh request withdraws the acknowledge even though the outside requester still holds its request. This asks the requester to give the bus back. The groups still float until the request has been seen negated for the required run of consecutive clock edges.

Top module: `bus_release_arb`

## Requirements
- R1: When reset is asserted, the block is in the owned state: `breq_ack_no`=1, all three group enables are 1, `strobe_idle_o`=0, `pchg_cmd_o`=0 and `bus_owned_o`=1.
- R2: `breq_ni` is sampled only on rising clock edges. A low sample taken while the bus is owned starts the release on the following edge. At that edge `bus_owned_o` falls.
- R3: While `cycle_busy_i` is high during a release, the block holds the bus with every group enabled and does not assert the acknowledge.
- R4: If `bank_open_i` is high when the bus cycle ends, `pchg_cmd_o` stays high until `pchg_done_i` is sampled high. The acknowledge falls on the edge after that sample and never while `pchg_cmd_o` is high.
- R5: The acknowledge goes low for one cycle while all groups are still enabled. On the next edge all three enables drop to 0.
- R6: `strobe_idle_o` is high in the cycle before the control enable drops.
- R7: On reclaim, the acknowledge returns high and the control enable rises on the same edge, while address and data stay floated. Both address and data enables rise on the next edge.
- R8: `bus_owned_o` is high only when the control, address and data enables are all high. After a reclaim it rises on the same edge as the address/data enables.
- R9: A high `refresh_req_i` sampled while the bus is released drives `breq_ack_no` high from the next edge onward, with all groups still floated. The block reclaims only through the normal negation rule. The withdrawal does not carry over into the next release.
- R10: The block reclaims on the edge after the one where `breq_ni` has been sampled high on `NEG_CYCLES` consecutive edges. Any low sample restarts that count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| breq_ni | input | 1 | External bus request, active low |
| cycle_busy_i | input | 1 | A bus cycle is in progress |
| bank_open_i | input | 1 | A DRAM/SDRAM bank is open |
| pchg_done_i | input | 1 | Precharge has completed |
| refresh_req_i | input | 1 | Internal refresh wants the bus |
| breq_ack_no | output | 1 | Bus grant acknowledge, active low |
| ctrl_oe_o | output | 1 | Output enable of the control strobes |
| addr_oe_o | output | 1 | Output enable of the address bus |
| data_oe_o | output | 1 | Output enable of the data bus |
| strobe_idle_o | output | 1 | Forces control strobes to their inactive level |
| pchg_cmd_o | output | 1 | Requests a precharge of open banks |
| bus_owned_o | output | 1 | Address/data driven, internal cycles may start |

## Verification
The bench builds the block with `NEG_CYCLES`=3 instead of the default 2. With that value, a counter that is off by one edge, or that saturates early, shows up as a misplaced reclaim cycle. It also leaves room to inject a single low sample in the middle of a run of high samples. That tests the restart rule in R10 without the reclaim firing first. The value keeps the reclaim window short enough that every release path can be walked edge by edge: plain, busy, precharge, refresh-withdrawn and glitched.

// File: rtl/bus_rel_pkg.sv
package bus_rel_pkg;
  typedef enum logic [2:0] {
    ST_OWNED,
    ST_WAIT_END,
    ST_PRECHG,
    ST_ACK,
    ST_RELEASED,
    ST_RECL_CTRL,
    ST_RECL_ADDR
  } rel_state_e;
endpackage

// File: rtl/bus_req_sampler.sv
module bus_req_sampler #(
  parameter int NEG_CYCLES = 2,
  localparam int CNT_W = $clog2(NEG_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic breq_ni,
  output logic req_o,
  output logic neg_ok_o
);
  localparam logic [CNT_W-1:0] NEG_MAX = CNT_W'(NEG_CYCLES);

  logic [CNT_W-1:0] neg_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o     <= 1'b0;
      neg_cnt_q <= '0;
    end else begin
      req_o <= ~breq_ni;
      if (!breq_ni)             neg_cnt_q <= '0;
      else if (neg_cnt_q != NEG_MAX) neg_cnt_q <= neg_cnt_q + 1'b1;
    end
  end

  assign neg_ok_o = (neg_cnt_q == NEG_MAX);

  a_r10_low_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !breq_ni |=> neg_cnt_q == '0);
  a_r10_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    neg_cnt_q <= NEG_MAX);
endmodule

// File: rtl/bus_rel_fsm.sv
module bus_rel_fsm
  import bus_rel_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       neg_ok_i,
  input  logic       cycle_busy_i,
  input  logic       bank_open_i,
  input  logic       pchg_done_i,
  input  logic       refresh_req_i,
  output rel_state_e state_o,
  output logic       rfsh_pend_o
);
  rel_state_e state_q, state_d;
  logic       rfsh_q, rfsh_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OWNED:     if (req_i) state_d = cycle_busy_i ? ST_WAIT_END :
                                        (bank_open_i ? ST_PRECHG : ST_ACK);
      ST_WAIT_END:  if (!cycle_busy_i) state_d = bank_open_i ? ST_PRECHG : ST_ACK;
      ST_PRECHG:    if (pchg_done_i) state_d = ST_ACK;
      ST_ACK:       state_d = ST_RELEASED;
      ST_RELEASED:  if (neg_ok_i) state_d = ST_RECL_CTRL;
      ST_RECL_CTRL: state_d = ST_RECL_ADDR;
      ST_RECL_ADDR: state_d = ST_OWNED;
      default:      state_d = ST_OWNED;
    endcase
  end

  // refresh withdrawal lives only while released and not yet reclaiming
  assign rfsh_d = (state_q == ST_RELEASED) && !neg_ok_i && (rfsh_q || refresh_req_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OWNED;
      rfsh_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      rfsh_q  <= rfsh_d;
    end
  end

  assign state_o     = state_q;
  assign rfsh_pend_o = rfsh_q;

  a_r3_hold_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT_END) && cycle_busy_i |=> state_q == ST_WAIT_END);
  a_r9_pend_persists: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rfsh_q && (state_q == ST_RELEASED) && !neg_ok_i |=> rfsh_q);
  a_r10_reclaim_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RELEASED) && !neg_ok_i |=> state_q == ST_RELEASED);
endmodule

// File: rtl/bus_oe_decode.sv
module bus_oe_decode
  import bus_rel_pkg::*;
(
  input  rel_state_e state_i,
  input  logic       rfsh_pend_i,
  output logic       ack_no,
  output logic       ctrl_oe_o,
  output logic       addr_oe_o,
  output logic       data_oe_o,
  output logic       strobe_idle_o,
  output logic       pchg_cmd_o,
  output logic       bus_owned_o
);
  logic ad_oe;

  always_comb begin
    ack_no        = 1'b1;
    ctrl_oe_o     = 1'b1;
    ad_oe         = 1'b1;
    strobe_idle_o = 1'b0;
    pchg_cmd_o    = 1'b0;
    bus_owned_o   = 1'b0;
    unique case (state_i)
      ST_OWNED, ST_RECL_ADDR: bus_owned_o = 1'b1;
      ST_WAIT_END: ;
      ST_PRECHG:   pchg_cmd_o = 1'b1;
      ST_ACK: begin
        ack_no        = 1'b0;
        strobe_idle_o = 1'b1;
      end
      ST_RELEASED: begin
        ack_no        = rfsh_pend_i;
        ctrl_oe_o     = 1'b0;
        ad_oe         = 1'b0;
        strobe_idle_o = 1'b1;
      end
      ST_RECL_CTRL: begin
        ad_oe         = 1'b0;
        strobe_idle_o = 1'b1;
      end
      default: ;
    endcase
  end

  assign addr_oe_o = ad_oe;
  assign data_oe_o = ad_oe;
endmodule

// File: rtl/bus_release_arb.sv
module bus_release_arb
  import bus_rel_pkg::*;
#(
  parameter int NEG_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic breq_ni,
  input  logic cycle_busy_i,
  input  logic bank_open_i,
  input  logic pchg_done_i,
  input  logic refresh_req_i,
  output logic breq_ack_no,
  output logic ctrl_oe_o,
  output logic addr_oe_o,
  output logic data_oe_o,
  output logic strobe_idle_o,
  output logic pchg_cmd_o,
  output logic bus_owned_o
);
  logic       req_s, neg_ok;
  rel_state_e state;
  logic       rfsh_pend;

  bus_req_sampler #(.NEG_CYCLES(NEG_CYCLES)) u_sampler (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .breq_ni  (breq_ni),
    .req_o    (req_s),
    .neg_ok_o (neg_ok)
  );

  bus_rel_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_i         (req_s),
    .neg_ok_i      (neg_ok),
    .cycle_busy_i  (cycle_busy_i),
    .bank_open_i   (bank_open_i),
    .pchg_done_i   (pchg_done_i),
    .refresh_req_i (refresh_req_i),
    .state_o       (state),
    .rfsh_pend_o   (rfsh_pend)
  );

  bus_oe_decode u_decode (
    .state_i       (state),
    .rfsh_pend_i   (rfsh_pend),
    .ack_no        (breq_ack_no),
    .ctrl_oe_o     (ctrl_oe_o),
    .addr_oe_o     (addr_oe_o),
    .data_oe_o     (data_oe_o),
    .strobe_idle_o (strobe_idle_o),
    .pchg_cmd_o    (pchg_cmd_o),
    .bus_owned_o   (bus_owned_o)
  );

  a_r4_no_ack_in_prechg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pchg_cmd_o |-> breq_ack_no && ctrl_oe_o);
  a_r5_float_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(breq_ack_no) |=> !ctrl_oe_o && !addr_oe_o && !data_oe_o);
  a_r6_idle_before_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_oe_o) |-> $past(strobe_idle_o));
  a_r7_ctrl_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_oe_o) |-> breq_ack_no && !addr_oe_o && !data_oe_o);
  a_r7_addr_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_oe_o) |=> addr_oe_o && data_oe_o);
  a_r8_owned_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_owned_o |-> ctrl_oe_o && addr_oe_o && data_oe_o);
endmodule

// File: tb/bus_release_arb_bench.sv
`timescale 1ns/1ps
module bus_release_arb_bench;
  localparam int NEG = 3;
  // {ack_n, ctrl_oe, addr_oe, data_oe, strobe_idle, pchg_cmd, bus_owned}
  localparam logic [6:0] OWN  = 7'b1111001;
  localparam logic [6:0] WAIT = 7'b1111000;
  localparam logic [6:0] PCHG = 7'b1111010;
  localparam logic [6:0] ACKD = 7'b0111100;
  localparam logic [6:0] REL  = 7'b0000100;
  localparam logic [6:0] RELR = 7'b1000100;
  localparam logic [6:0] RCTL = 7'b1100100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic breq_n = 1'b1, busy = 1'b0, bank = 1'b0, pdone = 1'b0, rfsh = 1'b0;
  logic ack_n, c_oe, a_oe, d_oe, s_idle, pcmd, owned;
  logic [6:0] obs;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [6:0] qv[$];
  string      qt[$];

  always #10 clk = ~clk;

  bus_release_arb #(.NEG_CYCLES(NEG)) u_bus_release_arb (
    .clk_i(clk), .rst_ni(rst_n), .breq_ni(breq_n), .cycle_busy_i(busy),
    .bank_open_i(bank), .pchg_done_i(pdone), .refresh_req_i(rfsh),
    .breq_ack_no(ack_n), .ctrl_oe_o(c_oe), .addr_oe_o(a_oe), .data_oe_o(d_oe),
    .strobe_idle_o(s_idle), .pchg_cmd_o(pcmd), .bus_owned_o(owned)
  );

  assign obs = {ack_n, c_oe, a_oe, d_oe, s_idle, pcmd, owned};

  // monitor: compare the expectation queued for this edge
  always @(posedge clk) begin
    #1;
    if (qv.size() > 0) begin
      logic [6:0] e;
      string t;
      e = qv.pop_front();
      t = qt.pop_front();
      checks++;
      if (obs !== e) begin
        errors++;
        $display("FAIL %s got %b exp %b at %0t", t, obs, e, $time);
      end
    end
  end

  task automatic tick(input logic [6:0] e, input string tag);
    qv.push_back(e);
    qt.push_back(tag);
    @(posedge clk);
    #2;
  endtask

  task automatic reps(input logic [6:0] e, input string tag, input int n);
    for (int i = 0; i < n; i++) tick(e, tag);
  endtask

  task automatic reclaim(input logic [6:0] hold, input string tag);
    breq_n = 1'b1;
    reps(hold, "R10 negation run", NEG);
    tick(RCTL, {tag, " R7 ctrl first"});
    tick(OWN, "R8 addr/data back");
    tick(OWN, "R8 owned");
  endtask

  task automatic plain_release(input string tag);
    breq_n = 1'b0;
    tick(OWN, "R2 sample edge");
    tick(ACKD, {tag, " R5 ack with groups driven"});
    tick(REL, "R5 groups float");
  endtask

  initial begin
    #55;
    checks++;
    if (obs !== OWN) begin
      errors++;
      $display("FAIL R1 reset got %b exp %b", obs, OWN);
    end
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #2;
    reps(OWN, "R1 idle owned", 2);

    // plain release and reclaim
    plain_release("R2");
    reclaim(REL, "R7");

    // current cycle must end first
    breq_n = 1'b0; busy = 1'b1;
    tick(OWN, "R2 sample edge");
    reps(WAIT, "R3 busy hold", 3);
    busy = 1'b0;
    tick(ACKD, "R3 ack after cycle end");
    tick(REL, "R5 groups float");
    reclaim(REL, "R7");

    // precharge of an open bank
    breq_n = 1'b0; busy = 1'b1; bank = 1'b1;
    tick(OWN, "R2 sample edge");
    tick(WAIT, "R3 busy hold");
    busy = 1'b0;
    reps(PCHG, "R4 precharge pending", 3);
    pdone = 1'b1;
    tick(ACKD, "R4 ack after precharge done");
    pdone = 1'b0; bank = 1'b0;
    tick(REL, "R5 groups float");
    reclaim(REL, "R7");

    // refresh withdraws the grant while request is held
    plain_release("R9");
    rfsh = 1'b1;
    tick(RELR, "R9 ack withdrawn");
    rfsh = 1'b0;
    reps(RELR, "R9 still floated", 3);
    reclaim(RELR, "R9");
    plain_release("R9 pend cleared");
    reclaim(REL, "R7");

    // a single low sample restarts the negation count
    plain_release("R6");
    breq_n = 1'b1;
    reps(REL, "R10 partial run", NEG - 1);
    breq_n = 1'b0;
    tick(REL, "R10 glitch low");
    reclaim(REL, "R10");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule